// File: doc/BRIEF.md
# Five-Function Integer ALU with Zero Flag

This block is the arithmetic and logic stage of a simple single-issue integer core. It is purely combinational. It takes two operands of equal width and a 3-bit operation code. It returns a result word and a flag that is high when that word is all zeros.

The five functions are:
- bitwise AND
- bitwise OR
- wrapping addition, which the core also uses to form load and store addresses
- wrapping subtraction, which the core's branch logic also uses to test two registers for equality through the zero flag
- signed set-on-less-than

The two comparison-style codes, subtraction and set-on-less-than, both have the top select bit set. A single shared adder can therefore take that bit as its subtract control. The three remaining codes are reserved. They give a defined all-zero result.

The operand width and the adder arrangement are parameters. The default width is 32 bits.

Top module: `fivefn_alu`

## Requirements
- R1: With `op_sel` = 3'b000 the result is the bitwise AND of the two operands.
- R2: With `op_sel` = 3'b001 the result is the bitwise OR of the two operands.
- R3: With `op_sel` = 3'b010 the result is `opnd_a + opnd_b` modulo 2^WIDTH; a carry out of the top bit is discarded and no flag reports it.
- R4: With `op_sel` = 3'b110 the result is `opnd_a - opnd_b` modulo 2^WIDTH, with no overflow indication.
- R5: With `op_sel` = 3'b111 the result is 1 when `opnd_a` is less than `opnd_b` as signed two's complement numbers, and 0 otherwise; all upper result bits are zero. This holds across the sign boundary, for example most-negative < most-positive.
- R6: The reserved codes 3'b011, 3'b100 and 3'b101 give an all-zero result whatever the operands are.
- R7: `zero` is 1 exactly when every bit of `result` is 0, for every operation code.
- R8: Under subtraction, `zero` is 1 exactly when the two operands are equal. This is the branch equality test.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand (minuend for subtraction, left side of the comparison) |
| opnd_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation code |
| result | output | WIDTH | Computed result word |
| zero | output | 1 | High when `result` is all zeros |

## Verification
The checker compares the result with the code-specific value whenever the inputs settle. That covers AND, OR, wrapping add and subtract, the signed comparison, the zero result of reserved codes, and the agreement between the zero flag and the result word. The bench goes further than those per-evaluation checks. It sweeps every code against every operand pair of a 4-bit instance, which exercises every sign-boundary and wrap case. It also runs a 32-bit instance over corner values such as the most-negative and most-positive words and equal-operand subtractions.

// File: rtl/fivefn_alu_pkg.sv
package fivefn_alu_pkg;

   typedef enum logic [2:0] {
      OPC_AND = 3'b000,
      OPC_OR  = 3'b001,
      OPC_ADD = 3'b010,
      OPC_SUB = 3'b110,
      OPC_SLT = 3'b111
   } alu_opc_e;

   // adder arrangement selector
   localparam int ARITH_SHARED   = 0;
   localparam int ARITH_SEPARATE = 1;

endpackage

// File: rtl/fivefn_alu_logic.sv
module fivefn_alu_logic #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   output logic [WIDTH-1:0] and_out,
   output logic [WIDTH-1:0] or_out
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign and_out[i] = in_a[i] & in_b[i];
      assign or_out[i]  = in_a[i] | in_b[i];
   end
endmodule

// File: rtl/fivefn_alu_arith.sv
module fivefn_alu_arith
   import fivefn_alu_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int ARITH = ARITH_SHARED
) (
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   input  logic             sub_sel,
   output logic [WIDTH-1:0] sum_out,
   output logic [WIDTH-1:0] diff_out,
   output logic             lt_out
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] diff_w;
   logic             ovf_w;

   if (ARITH == ARITH_SHARED) begin : g_shared
      // one adder; the subtract control comes from the top select bit
      logic [WIDTH-1:0] b_eff;
      logic [WIDTH-1:0] adder_w;
      assign b_eff    = in_b ^ {WIDTH{sub_sel}};
      assign adder_w  = in_a + b_eff + {{(WIDTH-1){1'b0}}, sub_sel};
      assign sum_out  = adder_w;
      assign diff_w   = adder_w;
   end else begin : g_separate
      logic unused_sub_sel;
      assign unused_sub_sel = sub_sel;
      assign sum_out = in_a + in_b;
      assign diff_w  = in_a - in_b;
   end

   assign diff_out = diff_w;
   // signed overflow of a-b is used only internally for the comparison
   assign ovf_w  = (in_a[MSB] ^ in_b[MSB]) & (in_a[MSB] ^ diff_w[MSB]);
   assign lt_out = diff_w[MSB] ^ ovf_w;
endmodule

// File: rtl/fivefn_alu_select.sv
module fivefn_alu_select
   import fivefn_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [2:0]       opc,
   input  logic [WIDTH-1:0] and_in,
   input  logic [WIDTH-1:0] or_in,
   input  logic [WIDTH-1:0] sum_in,
   input  logic [WIDTH-1:0] diff_in,
   input  logic             lt_in,
   output logic [WIDTH-1:0] res_out,
   output logic             zero_out
);
   always_comb begin
      unique case (opc)
         OPC_AND: res_out = and_in;
         OPC_OR:  res_out = or_in;
         OPC_ADD: res_out = sum_in;
         OPC_SUB: res_out = diff_in;
         OPC_SLT: res_out = {{(WIDTH-1){1'b0}}, lt_in};
         default: res_out = '0;
      endcase
   end

   assign zero_out = ~|res_out;
endmodule

// File: rtl/fivefn_alu.sv
module fivefn_alu
   import fivefn_alu_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int ARITH = ARITH_SHARED
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [2:0]       op_sel,
   output logic [WIDTH-1:0] result,
   output logic             zero
);
   if (WIDTH < 2) begin : g_bad_width
      $error("fivefn_alu: WIDTH must be at least 2");
   end
   if (ARITH != ARITH_SHARED && ARITH != ARITH_SEPARATE) begin : g_bad_arith
      $error("fivefn_alu: unknown ARITH selection");
   end

   logic [WIDTH-1:0] and_w, or_w, sum_w, diff_w;
   logic             lt_w;

   fivefn_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .in_a    (opnd_a),
      .in_b    (opnd_b),
      .and_out (and_w),
      .or_out  (or_w)
   );

   fivefn_alu_arith #(.WIDTH(WIDTH), .ARITH(ARITH)) u_arith (
      .in_a     (opnd_a),
      .in_b     (opnd_b),
      .sub_sel  (op_sel[2]),
      .sum_out  (sum_w),
      .diff_out (diff_w),
      .lt_out   (lt_w)
   );

   fivefn_alu_select #(.WIDTH(WIDTH)) u_sel (
      .opc      (op_sel),
      .and_in   (and_w),
      .or_in    (or_w),
      .sum_in   (sum_w),
      .diff_in  (diff_w),
      .lt_in    (lt_w),
      .res_out  (result),
      .zero_out (zero)
   );
endmodule

// File: rtl/fivefn_alu_chk.sv
module fivefn_alu_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic [2:0]       op_sel,
   input logic [WIDTH-1:0] result,
   input logic             zero
);
   logic known;
   assign known = !$isunknown({opnd_a, opnd_b, op_sel});

   always_comb begin
      if (known) begin
         if (op_sel == 3'b000)
            a_r1_and_bits: assert (result == (opnd_a & opnd_b));
         if (op_sel == 3'b001)
            a_r2_or_bits: assert (result == (opnd_a | opnd_b));
         if (op_sel == 3'b010)
            a_r3_add_wraps: assert (result == WIDTH'(opnd_a + opnd_b));
         if (op_sel == 3'b110)
            a_r4_sub_wraps: assert (result == WIDTH'(opnd_a - opnd_b));
         if (op_sel == 3'b111)
            a_r5_signed_less: assert (result ==
               {{(WIDTH-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))});
         if (op_sel == 3'b011 || op_sel == 3'b100 || op_sel == 3'b101)
            a_r6_reserved_zero: assert (result == '0);
         a_r7_flag_agrees: assert (zero == (result == '0));
         if (op_sel == 3'b110)
            a_r8_branch_equal: assert (zero == (opnd_a == opnd_b));
      end
   end
endmodule

bind fivefn_alu fivefn_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .opnd_a (opnd_a),
   .opnd_b (opnd_b),
   .op_sel (op_sel),
   .result (result),
   .zero   (zero)
);

// File: tb/fivefn_alu_test.sv
module fivefn_alu_test;
   import fivefn_alu_pkg::*;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // small instance, separate adders, swept exhaustively
   logic [3:0] s_a, s_b, s_res;
   logic [2:0] s_op;
   logic       s_zero;

   fivefn_alu #(.WIDTH(4), .ARITH(ARITH_SEPARATE)) uut_small (
      .opnd_a(s_a), .opnd_b(s_b), .op_sel(s_op), .result(s_res), .zero(s_zero)
   );

   // full-width instance, shared adder
   logic [31:0] a, b, res;
   logic [2:0]  op;
   logic        zf;

   fivefn_alu uut (
      .opnd_a(a), .opnd_b(b), .op_sel(op), .result(res), .zero(zf)
   );

   function automatic string req_of(input int code);
      case (code)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         6: return "R4";
         7: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // arithmetic model on integers for the 4-bit instance
   function automatic int exp_small(input int code, input int x, input int y);
      int sx, sy, ax, ay, r;
      sx = (x >= 8) ? x - 16 : x;
      sy = (y >= 8) ? y - 16 : y;
      r = 0;
      case (code)
         0, 1: begin
            ax = x; ay = y;
            for (int k = 0; k < 4; k++) begin
               if (code == 0 && (ax % 2 == 1) && (ay % 2 == 1)) r += (1 << k);
               if (code == 1 && ((ax % 2 == 1) || (ay % 2 == 1))) r += (1 << k);
               ax /= 2; ay /= 2;
            end
         end
         2: r = (x + y) % 16;
         6: r = (x - y + 16) % 16;
         7: r = (sx < sy) ? 1 : 0;
         default: r = 0;
      endcase
      return r;
   endfunction

   function automatic logic [31:0] exp_wide(input int code, input logic [31:0] x, input logic [31:0] y);
      longint sx, sy;
      longint unsigned t;
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      case (code)
         0: return x & y;
         1: return x | y;
         2: begin t = longint'(x) + longint'(y); return t[31:0]; end
         6: begin t = longint'(x) + 64'h1_0000_0000 - longint'(y); return t[31:0]; end
         7: return (sx < sy) ? 32'd1 : 32'd0;
         default: return 32'd0;
      endcase
   endfunction

   initial begin
      #200000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] corn [8];
      corn[0] = 32'h0000_0000; corn[1] = 32'h0000_0001;
      corn[2] = 32'hFFFF_FFFF; corn[3] = 32'h7FFF_FFFF;
      corn[4] = 32'h8000_0000; corn[5] = 32'h1234_5678;
      corn[6] = 32'h0000_A37C; corn[7] = 32'hFFFF_FFFC;

      // quiescent start: zero operands, AND code
      s_a = '0; s_b = '0; s_op = 3'b000;
      a = '0; b = '0; op = 3'b000;
      @(negedge clk);
      cmp("R1", res, 32'd0);
      cmp("R7", {31'd0, zf}, 32'd1);

      // exhaustive sweep of the 4-bit instance
      for (int c = 0; c < 8; c++) begin
         for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
               @(posedge clk);
               s_op = 3'(c); s_a = 4'(x); s_b = 4'(y);
               @(negedge clk);
               begin
                  int e;
                  e = exp_small(c, x, y);
                  cmp(req_of(c), {28'd0, s_res}, 32'(e));
                  cmp("R7", {31'd0, s_zero}, (e == 0) ? 32'd1 : 32'd0);
                  if (c == 6)
                     cmp("R8", {31'd0, s_zero}, (x == y) ? 32'd1 : 32'd0);
               end
            end
         end
      end

      // corner sweep of the 32-bit instance
      for (int c = 0; c < 8; c++) begin
         for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
               @(posedge clk);
               op = 3'(c); a = corn[i]; b = corn[j];
               @(negedge clk);
               begin
                  logic [31:0] e;
                  e = exp_wide(c, corn[i], corn[j]);
                  cmp(req_of(c), res, e);
                  cmp("R7", {31'd0, zf}, (e == 0) ? 32'd1 : 32'd0);
                  if (c == 6)
                     cmp("R8", {31'd0, zf}, (i == j) ? 32'd1 : 32'd0);
               end
            end
         end
      end

      // directed: most-negative < most-positive, and not the reverse (R5)
      @(posedge clk); op = 3'b111; a = 32'h8000_0000; b = 32'h7FFF_FFFF;
      @(negedge clk); cmp("R5", res, 32'd1);
      @(posedge clk); a = 32'h7FFF_FFFF; b = 32'h8000_0000;
      @(negedge clk); cmp("R5", res, 32'd0);
      // directed: add carry-out discarded (R3)
      @(posedge clk); op = 3'b010; a = 32'hFFFF_FFFF; b = 32'h0000_0001;
      @(negedge clk); cmp("R3", res, 32'd0); cmp("R7", {31'd0, zf}, 32'd1);
      // directed: reserved code with all-ones operands (R6)
      @(posedge clk); op = 3'b101; a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF;
      @(negedge clk); cmp("R6", res, 32'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule